// File: doc/BRIEF.md
# Time-Aligned Pulse-Per-Second Generator

This block turns a running time-of-day value (whole seconds plus a sub-second count) into a timing pulse. It has two modes. In fixed-rate mode a 4-bit rate selector picks either a once-per-second pulse aligned to the seconds boundary or a square wave tapped from the sub-second count. The frequency of that square wave depends on whether the sub-second count wraps at a power of two (binary rollover) or at one billion nanoseconds (digital rollover).

In command mode a 3-bit command code, qualified by a valid strobe, schedules pulses against absolute time. A start command latches a target time, a pulse interval and a pulse width. Nothing happens until the time of day reaches or passes the target. From that point the block emits either one pulse or a periodic train. The train can be stopped at a later target time or at once, and a pending start or a pending stop can be withdrawn. Interval and width are counted in sub-second increment ticks. A busy flag shows that a scheduled action is still outstanding.

Top module: `pps_pulse_gen`

## Requirements
- R1: Fixed mode, selector 0. The output is high during the first half of each second and low in the second half, one clock after the time input. In binary rollover the first half is sub-second bit 30 clear. In digital rollover it is a sub-second value below 500,000,000.
- R2: Fixed mode, selector n in 1..15. The output follows sub-second bit (30-n), one clock later. With binary rollover this gives 2^n Hz. With digital rollover, whose range ends below 2^30, it gives about 2^(n-1) Hz.
- R3: Command codes are 1 = start one pulse and 2 = start a train. Either one latches the target, interval and width, and the output stays low until {seconds, sub-seconds} >= {target seconds, target sub-seconds}, compared as one unsigned value with the seconds in the upper half. The first pulse appears one clock after the comparison first succeeds, and a target already in the past succeeds at once.
- R4: In a train the output is high for the first `width` ticks of each period of `interval` ticks. If width >= interval, the output stays high for the whole train.
- R5: A single pulse stays high for `width` ticks. The block then returns to idle with the output low.
- R6: Code 3 (cancel start), given while a start is pending, returns the block to idle. The output stays low, including after the target passes.
- R7: Code 4 (stop at time) is accepted while a train runs and latches a new target. The output goes low and the block idles once that target is reached. Code 6 (cancel stop), given before that, keeps the train running unchanged.
- R8: Code 5 (stop now) during a run forces the output low on the next clock and returns the block to idle.
- R9: The busy flag is high from the clock after a start or stop-at-time command is accepted until that start fires, that stop takes effect, or the command is cancelled.
- R10: Code 7 has no effect: busy and output are unchanged, and a running train keeps its pattern.
- R11: Reset drives the output and the busy flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tod_sec_i | input | 32 | Current whole seconds |
| tod_sub_i | input | 32 | Current sub-second count |
| digital_roll_i | input | 1 | 1: sub-second wraps at 10^9; 0: binary wrap at 2^31 |
| sub_tick_i | input | 1 | Sub-second increment tick this cycle |
| cmd_mode_i | input | 1 | 1: command mode; 0: fixed-rate mode |
| rate_sel_i | input | 4 | Fixed-mode rate selector |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command code |
| pulse_interval_i | input | 32 | Train period in ticks |
| pulse_width_i | input | 32 | High time in ticks |
| target_sec_i | input | 32 | Target seconds |
| target_sub_i | input | 32 | Target sub-second count |
| pps_o | output | 1 | Pulse output |
| busy_o | output | 1 | Scheduled command outstanding |

## Verification
Fixed mode is driven with random selectors, rollover modes and sub-second values, plus directed values on both sides of the half-second points. These show whether the correct tap is used and whether the two rollover modes are told apart. Command mode is driven through directed sequences: train, single pulse, past target, future-second target, cancel start, stop at time, cancel stop, stop now, and code 7 both while idle and while running. Each sequence has an expected output and busy profile per clock, computed from the target and the tick count. The width-not-below-interval train separates a correct phase wrap from one that drops the output between periods.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int CMD_W = 3;

    localparam logic [CMD_W-1:0] CMD_IDLE_CODE    = 3'd0;
    localparam logic [CMD_W-1:0] CMD_START_ONE    = 3'd1;
    localparam logic [CMD_W-1:0] CMD_START_TRAIN  = 3'd2;
    localparam logic [CMD_W-1:0] CMD_CANCEL_START = 3'd3;
    localparam logic [CMD_W-1:0] CMD_STOP_AT      = 3'd4;
    localparam logic [CMD_W-1:0] CMD_STOP_NOW     = 3'd5;
    localparam logic [CMD_W-1:0] CMD_CANCEL_STOP  = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

endpackage

// File: rtl/pps_time_cmp.sv
module pps_time_cmp #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 32
) (
    input  logic [SEC_W-1:0] now_sec_i,
    input  logic [SUB_W-1:0] now_sub_i,
    input  logic [SEC_W-1:0] tgt_sec_i,
    input  logic [SUB_W-1:0] tgt_sub_i,
    output logic             reached_o
);
    localparam int TOT_W = SEC_W + SUB_W;

    logic [TOT_W-1:0] now_all;
    logic [TOT_W-1:0] tgt_all;

    always_comb begin
        now_all   = {now_sec_i, now_sub_i};
        tgt_all   = {tgt_sec_i, tgt_sub_i};
        reached_o = (now_all >= tgt_all);
    end

endmodule

// File: rtl/pps_fixed_rate.sv
module pps_fixed_rate #(
    parameter int SUB_W      = 32,
    parameter int SEL_W      = 4,
    parameter int BIN_MSB    = 30,
    parameter int NS_PER_SEC = 1000000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUB_W-1:0] sub_i,
    input  logic             digital_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             pps_o
);
    localparam int NSEL = 1 << SEL_W;
    localparam logic [SUB_W-1:0] HALF_NS = SUB_W'(NS_PER_SEC / 2);

    typedef struct packed {
        logic pps;
    } fix_reg_t;

    fix_reg_t r_d, r_q;
    logic [NSEL-1:0] taps;

    // Tap 0: second-aligned half-second high window, depends on rollover.
    assign taps[0] = digital_i ? (sub_i < HALF_NS) : ~sub_i[BIN_MSB];

    generate
        for (genvar n = 1; n < NSEL; n++) begin : g_tap
            assign taps[n] = sub_i[BIN_MSB-n];
        end
    endgenerate

    always_comb begin
        r_d     = r_q;
        r_d.pps = taps[sel_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pps_o = r_q.pps;

    assert_bin_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == '0 && !digital_i) |=> (pps_o == !$past(sub_i[BIN_MSB])));

    assert_dig_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == '0 && digital_i) |=> (pps_o == ($past(sub_i) < HALF_NS)));

    assert_rate_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != '0) |=> (pps_o == $past(sub_i[BIN_MSB - int'(sel_i)])));

endmodule

// File: rtl/pps_cmd_engine.sv
module pps_cmd_engine
    import pps_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic [SEC_W-1:0] now_sec_i,
    input  logic [SUB_W-1:0] now_sub_i,
    input  logic             cmd_valid_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic [SEC_W-1:0] tgt_sec_i,
    input  logic [SUB_W-1:0] tgt_sub_i,
    output logic             pps_o,
    output logic             busy_o
);
    typedef struct packed {
        run_state_e       state;
        logic             single;
        logic             stop_pend;
        logic [SEC_W-1:0] tsec;
        logic [SUB_W-1:0] tsub;
        logic [CNT_W-1:0] ivl;
        logic [CNT_W-1:0] wid;
        logic [CNT_W-1:0] ph;
        logic             pps;
    } eng_reg_t;

    eng_reg_t r_d, r_q;
    logic reached;
    logic [CNT_W:0] ph_inc;
    logic cmd_start, cmd_cancel_start, cmd_stop_at, cmd_stop_now, cmd_cancel_stop;

    pps_time_cmp #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_cmp (
        .now_sec_i (now_sec_i),
        .now_sub_i (now_sub_i),
        .tgt_sec_i (r_q.tsec),
        .tgt_sub_i (r_q.tsub),
        .reached_o (reached)
    );

    always_comb begin
        cmd_start        = cmd_valid_i && (cmd_i == CMD_START_ONE || cmd_i == CMD_START_TRAIN);
        cmd_cancel_start = cmd_valid_i && (cmd_i == CMD_CANCEL_START);
        cmd_stop_at      = cmd_valid_i && (cmd_i == CMD_STOP_AT);
        cmd_stop_now     = cmd_valid_i && (cmd_i == CMD_STOP_NOW);
        cmd_cancel_stop  = cmd_valid_i && (cmd_i == CMD_CANCEL_STOP);
        ph_inc           = {1'b0, r_q.ph} + {{CNT_W{1'b0}}, 1'b1};

        r_d = r_q;
        if (!enable_i) begin
            r_d.state     = ST_IDLE;
            r_d.stop_pend = 1'b0;
            r_d.ph        = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        r_d.state  = ST_WAIT;
                        r_d.single = (cmd_i == CMD_START_ONE);
                        r_d.tsec   = tgt_sec_i;
                        r_d.tsub   = tgt_sub_i;
                        r_d.ivl    = interval_i;
                        r_d.wid    = width_i;
                        r_d.ph     = '0;
                    end
                end
                ST_WAIT: begin
                    if (cmd_cancel_start) begin
                        r_d.state = ST_IDLE;
                    end else if (reached) begin
                        r_d.state = ST_RUN;
                        r_d.ph    = '0;
                    end
                end
                ST_RUN: begin
                    if (cmd_stop_now) begin
                        r_d.state     = ST_IDLE;
                        r_d.stop_pend = 1'b0;
                    end else if (r_q.stop_pend && reached) begin
                        r_d.state     = ST_IDLE;
                        r_d.stop_pend = 1'b0;
                    end else begin
                        if (cmd_stop_at && !r_q.single && !r_q.stop_pend) begin
                            r_d.stop_pend = 1'b1;
                            r_d.tsec      = tgt_sec_i;
                            r_d.tsub      = tgt_sub_i;
                        end else if (cmd_cancel_stop && r_q.stop_pend) begin
                            r_d.stop_pend = 1'b0;
                        end
                        if (tick_i) begin
                            if (r_q.single) begin
                                if (ph_inc >= {1'b0, r_q.wid}) r_d.state = ST_IDLE;
                                else                          r_d.ph    = ph_inc[CNT_W-1:0];
                            end else begin
                                if (ph_inc >= {1'b0, r_q.ivl}) r_d.ph = '0;
                                else                          r_d.ph = ph_inc[CNT_W-1:0];
                            end
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
        r_d.pps = (r_d.state == ST_RUN) && (r_d.ph < r_d.wid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pps_o  = r_q.pps;
    assign busy_o = (r_q.state == ST_WAIT) || r_q.stop_pend;

    assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && !reached) |=> !pps_o);

    assert_full_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && !r_q.single && r_q.ivl != '0 && r_q.wid >= r_q.ivl) |-> pps_o);

    assert_cancel_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && r_q.state == ST_WAIT && cmd_cancel_start) |=> (!pps_o && !busy_o));

    assert_stop_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && r_q.state == ST_RUN && cmd_stop_now) |=> (!pps_o && !busy_o));

    assert_code7_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && r_q.state == ST_IDLE && cmd_valid_i && cmd_i == 3'd7) |=> (!pps_o && !busy_o));

endmodule

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen
    import pps_pkg::*;
#(
    parameter int SEC_W      = 32,
    parameter int SUB_W      = 32,
    parameter int CNT_W      = 32,
    parameter int SEL_W      = 4,
    parameter int BIN_MSB    = 30,
    parameter int NS_PER_SEC = 1000000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] tod_sec_i,
    input  logic [SUB_W-1:0] tod_sub_i,
    input  logic             digital_roll_i,
    input  logic             sub_tick_i,
    input  logic             cmd_mode_i,
    input  logic [SEL_W-1:0] rate_sel_i,
    input  logic             cmd_valid_i,
    input  logic [CMD_W-1:0] cmd_code_i,
    input  logic [CNT_W-1:0] pulse_interval_i,
    input  logic [CNT_W-1:0] pulse_width_i,
    input  logic [SEC_W-1:0] target_sec_i,
    input  logic [SUB_W-1:0] target_sub_i,
    output logic             pps_o,
    output logic             busy_o
);
    typedef struct packed {
        logic mode;
    } top_reg_t;

    top_reg_t r_d, r_q;
    logic fix_pps, cmd_pps, cmd_busy;

    pps_fixed_rate #(
        .SUB_W(SUB_W), .SEL_W(SEL_W), .BIN_MSB(BIN_MSB), .NS_PER_SEC(NS_PER_SEC)
    ) u_fixed (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_i     (tod_sub_i),
        .digital_i (digital_roll_i),
        .sel_i     (rate_sel_i),
        .pps_o     (fix_pps)
    );

    pps_cmd_engine #(.SEC_W(SEC_W), .SUB_W(SUB_W), .CNT_W(CNT_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (cmd_mode_i),
        .tick_i      (sub_tick_i),
        .now_sec_i   (tod_sec_i),
        .now_sub_i   (tod_sub_i),
        .cmd_valid_i (cmd_valid_i),
        .cmd_i       (cmd_code_i),
        .interval_i  (pulse_interval_i),
        .width_i     (pulse_width_i),
        .tgt_sec_i   (target_sec_i),
        .tgt_sub_i   (target_sub_i),
        .pps_o       (cmd_pps),
        .busy_o      (cmd_busy)
    );

    always_comb begin
        r_d      = r_q;
        r_d.mode = cmd_mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pps_o  = r_q.mode ? cmd_pps : fix_pps;
    assign busy_o = cmd_busy;

    assert_fixed_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_mode_i) |=> !busy_o);

endmodule

// File: tb/pps_pulse_gen_test.sv
`timescale 1ns/1ps
module pps_pulse_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] tod_sec, tod_sub, ivl, wid, tsec, tsub;
    logic        dig, tick, mode, cvalid;
    logic [3:0]  sel;
    logic [2:0]  ccode;
    logic        pps, busy;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int unsigned now;

    always #2.5 clk = ~clk;

    pps_pulse_gen uut (
        .clk(clk), .rst_n(rst_n), .tod_sec_i(tod_sec), .tod_sub_i(tod_sub),
        .digital_roll_i(dig), .sub_tick_i(tick), .cmd_mode_i(mode), .rate_sel_i(sel),
        .cmd_valid_i(cvalid), .cmd_code_i(ccode), .pulse_interval_i(ivl),
        .pulse_width_i(wid), .target_sec_i(tsec), .target_sub_i(tsub),
        .pps_o(pps), .busy_o(busy)
    );

    function automatic logic exp_fixed(logic [3:0] s, logic d, logic [31:0] v);
        if (s == 0) return d ? (v < 32'd500000000) : ~v[30];
        return v[30 - s];
    endfunction

    function automatic logic exp_train(int unsigned n, int unsigned t, int unsigned i, int unsigned w);
        if (n <= t + 0) return 1'b0;
        return ((n - t - 1) % i) < w;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b (now=%0d)", req, act, exp, now);
        end
    endtask

    task automatic adv();
        @(negedge clk);
        now++;
        tod_sub = now;
        cvalid  = 1'b0;
    endtask

    task automatic issue(logic [2:0] c, logic [31:0] s, logic [31:0] t, int unsigned i, int unsigned w);
        cvalid = 1'b1; ccode = c; tsec = s; tsub = t; ivl = i; wid = w;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        int unsigned tg, ss;
        void'($urandom(32'hC0FFEE));
        rst_n = 0; tod_sec = 0; tod_sub = 0; dig = 0; tick = 0; mode = 0; sel = 0;
        cvalid = 0; ccode = 0; ivl = 0; wid = 0; tsec = 0; tsub = 0; now = 0;
        repeat (4) @(negedge clk);
        chk("R11 reset pps", pps, 1'b0);
        chk("R11 reset busy", busy, 1'b0);
        rst_n = 1;

        // fixed mode: random patterns
        for (int k = 0; k < 400; k++) begin
            logic [3:0] s; logic d; logic [31:0] v;
            s = 4'($urandom); d = 1'($urandom);
            v = d ? ($urandom % 32'd1000000000) : ($urandom & 32'h7FFF_FFFF);
            @(negedge clk); sel = s; dig = d; tod_sub = v;
            @(negedge clk);
            chk(s == 0 ? "R1 fixed second" : "R2 fixed rate", pps, exp_fixed(s, d, v));
        end
        // fixed mode corners
        begin
            logic [3:0]  cs [6] = '{4'd0, 4'd0, 4'd0, 4'd0, 4'd15, 4'd1};
            logic        cd [6] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
            logic [31:0] cv [6] = '{32'd499999999, 32'd500000000, 32'h3FFF_FFFF,
                                    32'h4000_0000, 32'h0000_8000, 32'd600000000};
            for (int k = 0; k < 6; k++) begin
                @(negedge clk); sel = cs[k]; dig = cd[k]; tod_sub = cv[k];
                @(negedge clk);
                chk(k < 4 ? "R1 half-second edge" : "R2 tap edge", pps, exp_fixed(cs[k], cd[k], cv[k]));
            end
        end

        // command mode
        @(negedge clk); mode = 1; tick = 1; dig = 0; tod_sec = 5; now = 1000; tod_sub = now;
        repeat (3) adv();

        // code 7 while idle
        issue(3'd7, 5, now + 3, 4, 2);
        adv(); chk("R10 code7 idle busy", busy, 1'b0); chk("R10 code7 idle pps", pps, 1'b0);
        adv(); adv();

        // pulse train
        tg = now + 10;
        issue(3'd2, 5, tg, 4, 2);
        while (now < tg + 12) begin
            adv();
            chk("R3/R4 train", pps, exp_train(now, tg, 4, 2));
            chk("R9 busy during start", busy, now <= tg);
        end
        issue(3'd7, 5, 0, 1, 1);
        repeat (8) begin
            adv(); chk("R10 code7 running", pps, exp_train(now, tg, 4, 2));
            chk("R10 code7 busy", busy, 1'b0);
        end
        // stop at time
        ss = now + 9;
        issue(3'd4, 5, ss, 0, 0);
        while (now < ss + 4) begin
            adv();
            chk("R7 stop at time", pps, (now <= ss) ? exp_train(now, tg, 4, 2) : 1'b0);
            chk("R9 busy during stop", busy, now <= ss);
        end

        // train, cancel stop, then stop now
        tg = now + 3;
        issue(3'd2, 5, tg, 5, 3);
        while (now < tg + 6) begin adv(); chk("R4 train 5/3", pps, exp_train(now, tg, 5, 3)); end
        ss = now + 6;
        issue(3'd4, 5, ss, 0, 0);
        adv(); chk("R9 stop pending", busy, 1'b1); chk("R4 train", pps, exp_train(now, tg, 5, 3));
        adv();
        issue(3'd6, 0, 0, 0, 0);
        adv(); chk("R7 cancel stop busy", busy, 1'b0);
        while (now < ss + 8) begin adv(); chk("R7 train survives", pps, exp_train(now, tg, 5, 3)); end
        issue(3'd5, 0, 0, 0, 0);
        adv(); chk("R8 stop now pps", pps, 1'b0); chk("R8 stop now busy", busy, 1'b0);
        repeat (6) begin adv(); chk("R8 stays low", pps, 1'b0); end

        // single pulse
        tg = now + 4;
        issue(3'd1, 5, tg, 100, 3);
        while (now < tg + 8) begin
            adv();
            chk("R5 single", pps, (now > tg) && (now <= tg + 3));
            chk("R9 single busy", busy, now <= tg);
        end

        // cancel start
        tg = now + 20;
        issue(3'd1, 5, tg, 10, 5);
        repeat (3) begin adv(); chk("R9 pending start", busy, 1'b1); end
        issue(3'd3, 0, 0, 0, 0);
        adv(); chk("R6 cancel busy", busy, 1'b0);
        while (now < tg + 6) begin adv(); chk("R6 stays low", pps, 1'b0); end

        // target already in the past (earlier second, large sub-second)
        tg = now + 1;
        issue(3'd1, 4, 32'hFFFF_FFF0, 10, 2);
        adv(); chk("R3 past target wait", pps, 1'b0); chk("R9 past busy", busy, 1'b1);
        repeat (4) begin adv(); chk("R3 past target fires", pps, (now > tg) && (now <= tg + 2)); end

        // target in a later second never reached
        issue(3'd2, 6, 0, 4, 2);
        repeat (10) begin adv(); chk("R3 later second", pps, 1'b0); chk("R9 later busy", busy, 1'b1); end
        issue(3'd3, 0, 0, 0, 0);
        adv();

        // width not below interval: continuously high
        tg = now + 2;
        issue(3'd2, 5, tg, 3, 5);
        while (now < tg + 14) begin adv(); chk("R4 full high", pps, now > tg); end
        issue(3'd5, 0, 0, 0, 0);
        adv(); chk("R8 stop full", pps, 1'b0);

        done = 1;
        summary();
    end
endmodule